// File: doc/BRIEF.md
# Byte-wide host register interface

This block puts a serial-word controller, with two receive channels and one transmit channel, behind a small 8-bit processor bus. The bus uses active-low chip select, read strobe and write strobe, a 3-bit address, and separate 8-bit input and output data ports. All of these bus signals are synchronised into the system clock domain. Each strobe acts on its trailing (rising) edge, detected after the synchroniser.

A 32-bit serial word crosses the bus as four byte cycles. Receive words are read out and the transmit word is written in. Each data channel has its own byte counter. The block holds the control word, the two receiver label registers and the interrupt status bits for both receivers, and it builds the transmitter/general status byte. It drives a master reset and a reset for each receiver. The receive and transmit datapaths sit outside the block and connect through plain valid, flag and data ports.

Top module: `hbus_host_if`

## Requirements
- R1: A read at address 0b000 returns the interrupt status byte and a read at 0b011 returns the transmitter/general status byte. Any read with address bit 2 set returns 0x00. The data output is 0x00 whenever no read is in progress.
- R2: A read at 0b001 returns receiver 1's word and a read at 0b010 returns receiver 2's word. Byte k of the sequence (k = 0..3) is word bits [8k+7:8k], so serial bit 1 (word bit 0) appears on data bit 0 of the first byte.
- R3: After the four reads of a word, a fifth read at the same address returns the first byte again, and later reads keep cycling through the four bytes.
- R4: A write at 0b000 takes the input byte on the trailing edge of the write strobe, and each further byte needs a separate strobe pulse. After the fourth byte the block issues exactly one one-cycle `tx_push`, with `tx_word[8k+7:8k]` equal to byte k. No push happens after bytes 1 to 3.
- R5: If `tx_full` is high when the fourth byte is taken, no push is issued and the word is dropped.
- R6: A write at 0b011 loads the control word. Bit 0 and bit 1 hold the receiver 1 and receiver 2 resets active for as long as they are 1. Bit 2 is the parity select (1 = odd). Bits 3, 4 and 5 select the high rate for receiver 1, receiver 2 and the transmitter. Bits 7:6 are the clock select, driven on `clk_sel`.
- R7: In the interrupt status byte, bits 0/1/2 are receiver 1's word-received, parity-error and premature-idle flags, and bits 3/4/5 are the same flags for receiver 2. Bit 6 is `tx_empty` and bit 7 is `tx_full`. A received word sets word-received, loads the parity-error flag and clears the idle flag. An idle pulse sets the idle flag. A reset of that receiver clears all three flags.
- R8: The transmitter/general status byte carries `tx_ser_bit` on bit 0 and `tx_ser_clk` on bit 1. Bits 7:2 carry control bits 7:2 unchanged.
- R9: A write with address bit 2 set produces a single-cycle `master_reset`, whatever the data byte. The master reset also resets both receivers and clears their status flags. It leaves the control word and the label registers unchanged.
- R10: While `hard_reset_n` is low (after the synchroniser delay), `master_reset` is high for the same number of cycles. It has the same effects as R9 and also leaves the control word unchanged.
- R11: A write at 0b001 or 0b010 loads that receiver's label register and pulses that receiver's reset once. This happens again even when the value written equals the stored one. The other receiver's reset and flags are not affected.
- R12: Every byte counter goes back to the first byte when chip select goes high, when the address changes, or on a master reset.
- R13: The synchronous reset `rst` clears the control word, the labels, all flags, the byte counters and the data output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| hard_reset_n | input | 1 | Asynchronous active-low master reset pin, synchronised |
| bus_cs_n | input | 1 | Chip select, active low |
| bus_rd_n | input | 1 | Read strobe, active low |
| bus_wr_n | input | 1 | Write strobe, active low, data taken on rising edge |
| bus_addr | input | 3 | Register address |
| bus_din | input | 8 | Write data byte |
| bus_dout | output | 8 | Read data byte |
| rx1_data | input | 32 | Receiver 1 held word |
| rx1_valid | input | 1 | Receiver 1 word complete (one-cycle pulse) |
| rx1_par_err | input | 1 | Receiver 1 parity error, qualified by rx1_valid |
| rx1_idle_err | input | 1 | Receiver 1 premature idle pulse |
| rx2_data | input | 32 | Receiver 2 held word |
| rx2_valid | input | 1 | Receiver 2 word complete |
| rx2_par_err | input | 1 | Receiver 2 parity error |
| rx2_idle_err | input | 1 | Receiver 2 premature idle pulse |
| tx_empty | input | 1 | Transmitter and queue completely empty |
| tx_full | input | 1 | Transmit queue full |
| tx_ser_bit | input | 1 | Current serial transmit data bit |
| tx_ser_clk | input | 1 | Current serial transmit bit clock |
| tx_push | output | 1 | One-cycle push of an assembled transmit word |
| tx_word | output | 32 | Assembled transmit word |
| rx1_label | output | 8 | Receiver 1 label register |
| rx2_label | output | 8 | Receiver 2 label register |
| rx1_reset | output | 1 | Receiver 1 reset |
| rx2_reset | output | 1 | Receiver 2 reset |
| master_reset | output | 1 | Master reset to both datapaths |
| parity_odd | output | 1 | Parity select, 1 = odd |
| rx1_fast | output | 1 | Receiver 1 high-rate select |
| rx2_fast | output | 1 | Receiver 2 high-rate select |
| tx_fast | output | 1 | Transmitter high-rate select |
| clk_sel | output | 2 | Input clock select |

## Verification
Some properties can be checked on every cycle, and these are covered by assertions:
- A push never follows a full queue.
- Reads with address bit 2 set give zero.
- A label write is followed by that receiver's reset.
- A master reset leaves the control word stable.
- A receiver reset empties its flags.
- Write decodes are mutually exclusive.
- A byte counter is back at the first byte after a clear.

Other behaviour can only be shown by bench scenarios:
- The byte order within a word.
- The wrap on the fifth read.
- The counter return when chip select is released or the address changes.
- The exact status byte layouts.
- The count of master-reset cycles produced by the hardware pin.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

    localparam int BYTE_W     = 8;
    localparam int WORD_BYTES = 4;
    localparam int WORD_W     = BYTE_W * WORD_BYTES;
    localparam int ADDR_W     = 3;
    localparam int IDX_W      = $clog2(WORD_BYTES);
    localparam int NUM_RX     = 2;

    // Low two address bits select the function; the top bit selects
    // "zero read" / "master reset write".
    typedef enum logic [1:0] {
        FN_IRQ_TXW  = 2'd0,
        FN_RX1      = 2'd1,
        FN_RX2      = 2'd2,
        FN_GEN_CTRL = 2'd3
    } bus_fn_t;

    typedef struct packed {
        logic [1:0] clk_sel;    // bits 7:6
        logic       tx_fast;    // bit 5
        logic       rx2_fast;   // bit 4
        logic       rx1_fast;   // bit 3
        logic       parity_odd; // bit 2
        logic       rx2_rst;    // bit 1
        logic       rx1_rst;    // bit 0
    } ctrl_t;

    typedef struct packed {
        logic idle_err;         // bit 2 within a receiver group
        logic par_err;          // bit 1
        logic got;              // bit 0
    } rx_stat_t;

    function automatic logic [BYTE_W-1:0] word_byte(
        input logic [WORD_W-1:0] word,
        input logic [IDX_W-1:0]  idx
    );
        return word[idx*BYTE_W +: BYTE_W];
    endfunction

endpackage

// File: rtl/hbus_sync.sv
module hbus_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hbus_byte_seq.sv
module hbus_byte_seq
    import hbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic             step,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BYTES - 1);

    always_ff @(posedge clk) begin
        if (rst || clear)
            idx <= '0;
        else if (step)
            idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
    end

    // R12: a clear brings the counter back to the first byte
    assert_clear_first_R12: assert property (@(posedge clk) disable iff (rst)
        clear |=> (idx == '0));

    // R3: stepping past the last byte wraps to the first
    assert_wrap_first_R3: assert property (@(posedge clk) disable iff (rst)
        (step && !clear && idx == LAST_IDX) |=> (idx == '0));
endmodule

// File: rtl/hbus_rx_stat.sv
module hbus_rx_stat
    import hbus_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     clr,
    input  logic     valid,
    input  logic     par_err,
    input  logic     idle_err,
    output rx_stat_t stat
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            stat <= '0;
        end else if (valid) begin
            stat.got      <= 1'b1;
            stat.par_err  <= par_err;
            stat.idle_err <= 1'b0;
        end else if (idle_err) begin
            stat.idle_err <= 1'b1;
        end
    end

    // R7: a receiver reset empties all of its flags
    assert_reset_clears_R7: assert property (@(posedge clk) disable iff (rst)
        clr |=> (stat == '0));

    // R7: a completed word always leaves word-received set, idle cleared
    assert_word_sets_R7: assert property (@(posedge clk) disable iff (rst)
        (valid && !clr) |=> (stat.got && !stat.idle_err));
endmodule

// File: rtl/hbus_host_if.sv
module hbus_host_if
    import hbus_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hard_reset_n,
    input  logic              bus_cs_n,
    input  logic              bus_rd_n,
    input  logic              bus_wr_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_din,
    output logic [BYTE_W-1:0] bus_dout,
    input  logic [WORD_W-1:0] rx1_data,
    input  logic              rx1_valid,
    input  logic              rx1_par_err,
    input  logic              rx1_idle_err,
    input  logic [WORD_W-1:0] rx2_data,
    input  logic              rx2_valid,
    input  logic              rx2_par_err,
    input  logic              rx2_idle_err,
    input  logic              tx_empty,
    input  logic              tx_full,
    input  logic              tx_ser_bit,
    input  logic              tx_ser_clk,
    output logic              tx_push,
    output logic [WORD_W-1:0] tx_word,
    output logic [BYTE_W-1:0] rx1_label,
    output logic [BYTE_W-1:0] rx2_label,
    output logic              rx1_reset,
    output logic              rx2_reset,
    output logic              master_reset,
    output logic              parity_odd,
    output logic              rx1_fast,
    output logic              rx2_fast,
    output logic              tx_fast,
    output logic [1:0]        clk_sel
);
    localparam int BUNDLE_W = 4 + ADDR_W + BYTE_W;
    localparam logic [BUNDLE_W-1:0] BUNDLE_IDLE =
        {4'b1111, {ADDR_W{1'b0}}, {BYTE_W{1'b0}}};
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_BYTES - 1);
    localparam int TXBUF_W = WORD_W - BYTE_W;

    // ---------------- bus synchronisation and edge detection ----------
    logic [BUNDLE_W-1:0] bundle_s;
    logic                hrst_n_s, cs_n_s, rd_n_s, wr_n_s;
    logic [ADDR_W-1:0]   addr_s, addr_d;
    logic [BYTE_W-1:0]   din_s;
    logic                rd_n_d, wr_n_d;

    hbus_sync #(
        .W       (BUNDLE_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (BUNDLE_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({hard_reset_n, bus_cs_n, bus_rd_n, bus_wr_n, bus_addr, bus_din}),
        .q   (bundle_s)
    );

    assign {hrst_n_s, cs_n_s, rd_n_s, wr_n_s, addr_s, din_s} = bundle_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_n_d <= 1'b1;
            wr_n_d <= 1'b1;
            addr_d <= '0;
        end else begin
            rd_n_d <= rd_n_s;
            wr_n_d <= wr_n_s;
            addr_d <= addr_s;
        end
    end

    logic    wr_rise, rd_rise, hi_page;
    bus_fn_t fn;

    assign wr_rise = !cs_n_s && wr_n_s && !wr_n_d;
    assign rd_rise = !cs_n_s && rd_n_s && !rd_n_d;
    assign hi_page = addr_s[ADDR_W-1];
    assign fn      = bus_fn_t'(addr_s[1:0]);

    // ---------------- write decode ------------------------------------
    logic              wr_tx, wr_ctrl, wr_mr;
    logic [NUM_RX-1:0] wr_lbl;

    assign wr_tx     = wr_rise && !hi_page && (fn == FN_IRQ_TXW);
    assign wr_lbl[0] = wr_rise && !hi_page && (fn == FN_RX1);
    assign wr_lbl[1] = wr_rise && !hi_page && (fn == FN_RX2);
    assign wr_ctrl   = wr_rise && !hi_page && (fn == FN_GEN_CTRL);
    assign wr_mr     = wr_rise && hi_page;

    // R4: at most one write function fires per strobe edge
    assert_wr_decode_onehot_R4: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_tx, wr_lbl, wr_ctrl, wr_mr}));

    // ---------------- registers ---------------------------------------
    ctrl_t             ctrl_q;
    logic [BYTE_W-1:0] label_q [NUM_RX];
    logic              mr_q;
    logic [NUM_RX-1:0] lbl_pulse_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q      <= '0;
            mr_q        <= 1'b0;
            lbl_pulse_q <= '0;
            for (int i = 0; i < NUM_RX; i++) label_q[i] <= '0;
        end else begin
            mr_q        <= wr_mr;
            lbl_pulse_q <= wr_lbl;
            if (wr_ctrl) ctrl_q <= ctrl_t'(din_s);
            for (int i = 0; i < NUM_RX; i++)
                if (wr_lbl[i]) label_q[i] <= din_s;
        end
    end

    assign master_reset = mr_q || !hrst_n_s;

    logic [NUM_RX-1:0] rx_rst_v;
    assign rx_rst_v = {ctrl_q.rx2_rst, ctrl_q.rx1_rst} | lbl_pulse_q
                    | {NUM_RX{master_reset}};

    // R9: a master reset write leaves the control word untouched
    assert_mr_keeps_ctrl_R9: assert property (@(posedge clk) disable iff (rst)
        wr_mr |=> $stable(ctrl_q));

    // R11: a label write is followed by that receiver's reset
    assert_lbl_resets_rx1_R11: assert property (@(posedge clk) disable iff (rst)
        wr_lbl[0] |=> rx1_reset);
    assert_lbl_resets_rx2_R11: assert property (@(posedge clk) disable iff (rst)
        wr_lbl[1] |=> rx2_reset);

    // ---------------- byte sequencers and receiver status -------------
    logic              seq_clear;
    logic [WORD_W-1:0] rx_data  [NUM_RX];
    logic [NUM_RX-1:0] rx_valid, rx_perr, rx_idle;
    logic [IDX_W-1:0]  rx_idx   [NUM_RX];
    rx_stat_t          rx_stat  [NUM_RX];

    assign seq_clear  = cs_n_s || (addr_s != addr_d) || master_reset;
    assign rx_data[0] = rx1_data;
    assign rx_data[1] = rx2_data;
    assign rx_valid   = {rx2_valid, rx1_valid};
    assign rx_perr    = {rx2_par_err, rx1_par_err};
    assign rx_idle    = {rx2_idle_err, rx1_idle_err};

    for (genvar g = 0; g < NUM_RX; g++) begin : g_rx
        logic rd_step;
        assign rd_step = rd_rise && !hi_page && (addr_s[1:0] == 2'(g + 1));

        hbus_byte_seq u_seq (
            .clk   (clk),
            .rst   (rst),
            .clear (seq_clear),
            .step  (rd_step),
            .idx   (rx_idx[g])
        );

        hbus_rx_stat u_stat (
            .clk      (clk),
            .rst      (rst),
            .clr      (rx_rst_v[g]),
            .valid    (rx_valid[g]),
            .par_err  (rx_perr[g]),
            .idle_err (rx_idle[g]),
            .stat     (rx_stat[g])
        );
    end

    // ---------------- transmit word assembly --------------------------
    logic [IDX_W-1:0]   tx_idx;
    logic [TXBUF_W-1:0] tx_buf;
    logic               tx_last;

    hbus_byte_seq u_tx_seq (
        .clk   (clk),
        .rst   (rst),
        .clear (seq_clear),
        .step  (wr_tx),
        .idx   (tx_idx)
    );

    assign tx_last = (tx_idx == LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_buf  <= '0;
            tx_push <= 1'b0;
            tx_word <= '0;
        end else begin
            tx_push <= 1'b0;
            if (wr_tx && !tx_last)
                tx_buf[tx_idx*BYTE_W +: BYTE_W] <= din_s;
            if (wr_tx && tx_last && !tx_full && !master_reset) begin
                tx_push <= 1'b1;
                tx_word <= {din_s, tx_buf};
            end
        end
    end

    // R5: no push is issued against a full queue
    assert_push_not_full_R5: assert property (@(posedge clk) disable iff (rst)
        tx_push |-> !$past(tx_full));

    // ---------------- read path ---------------------------------------
    logic [BYTE_W-1:0] irq_byte, gen_byte, dout_nxt;

    assign irq_byte = {tx_full, tx_empty, rx_stat[1], rx_stat[0]};
    assign gen_byte = {ctrl_q.clk_sel, ctrl_q.tx_fast, ctrl_q.rx2_fast,
                       ctrl_q.rx1_fast, ctrl_q.parity_odd, tx_ser_clk, tx_ser_bit};

    always_comb begin
        dout_nxt = '0;
        if (!cs_n_s && !rd_n_s && !hi_page) begin
            unique case (fn)
                FN_IRQ_TXW:  dout_nxt = irq_byte;
                FN_RX1:      dout_nxt = word_byte(rx_data[0], rx_idx[0]);
                FN_RX2:      dout_nxt = word_byte(rx_data[1], rx_idx[1]);
                FN_GEN_CTRL: dout_nxt = gen_byte;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bus_dout <= '0;
        else     bus_dout <= dout_nxt;
    end

    // R1: the upper half of the address map reads as zero
    assert_hi_page_zero_R1: assert property (@(posedge clk) disable iff (rst)
        $past(hi_page) |-> (bus_dout == '0));

    // ---------------- outputs -----------------------------------------
    assign rx1_label  = label_q[0];
    assign rx2_label  = label_q[1];
    assign rx1_reset  = rx_rst_v[0];
    assign rx2_reset  = rx_rst_v[1];
    assign parity_odd = ctrl_q.parity_odd;
    assign rx1_fast   = ctrl_q.rx1_fast;
    assign rx2_fast   = ctrl_q.rx2_fast;
    assign tx_fast    = ctrl_q.tx_fast;
    assign clk_sel    = ctrl_q.clk_sel;
endmodule

// File: tb/test_hbus_host_if.sv
module test_hbus_host_if;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hard_reset_n = 1'b1;
    logic        bus_cs_n = 1'b1, bus_rd_n = 1'b1, bus_wr_n = 1'b1;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_din = '0;
    logic [7:0]  bus_dout;
    logic [31:0] rx1_data = '0, rx2_data = '0;
    logic        rx1_valid = 0, rx1_par_err = 0, rx1_idle_err = 0;
    logic        rx2_valid = 0, rx2_par_err = 0, rx2_idle_err = 0;
    logic        tx_empty = 0, tx_full = 0, tx_ser_bit = 0, tx_ser_clk = 0;
    logic        tx_push;
    logic [31:0] tx_word;
    logic [7:0]  rx1_label, rx2_label;
    logic        rx1_reset, rx2_reset, master_reset;
    logic        parity_odd, rx1_fast, rx2_fast, tx_fast;
    logic [1:0]  clk_sel;

    always #2.5 clk = ~clk;

    hbus_host_if i_hbus_host_if (.*);

    int checks = 0, errors = 0;
    bit done = 0;

    // port monitors
    int          push_cnt = 0, mr_cycles = 0, r1_pulses = 0, r2_pulses = 0;
    logic [31:0] last_push = '0;
    logic        r1_prev = 0, r2_prev = 0;
    always @(negedge clk) begin
        if (!rst) begin
            if (tx_push) begin push_cnt++; last_push = tx_word; end
            if (master_reset) mr_cycles++;
            if (rx1_reset && !r1_prev) r1_pulses++;
            if (rx2_reset && !r2_prev) r2_pulses++;
        end
        r1_prev = rx1_reset;
        r2_prev = rx2_reset;
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [7:0] d);
        bus_addr = a; bus_din = d; bus_cs_n = 1'b0;
        wait_n(4);
        bus_wr_n = 1'b0;
        wait_n(6);
        bus_wr_n = 1'b1;
        wait_n(6);
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [7:0] d);
        bus_addr = a; bus_cs_n = 1'b0;
        wait_n(4);
        bus_rd_n = 1'b0;
        wait_n(6);
        d = bus_dout;
        bus_rd_n = 1'b1;
        wait_n(6);
    endtask

    task automatic release_cs();
        bus_cs_n = 1'b1;
        wait_n(6);
    endtask

    task automatic wr_word(input logic [31:0] w);
        for (int k = 0; k < 4; k++) bus_wr(3'b000, w[8*k +: 8]);
        release_cs();
    endtask

    task automatic rx_pulse(input int ch, input bit valid, input bit perr, input bit idle);
        if (ch == 1) begin rx1_valid = valid; rx1_par_err = perr; rx1_idle_err = idle; end
        else         begin rx2_valid = valid; rx2_par_err = perr; rx2_idle_err = idle; end
        wait_n(1);
        rx1_valid = 0; rx1_par_err = 0; rx1_idle_err = 0;
        rx2_valid = 0; rx2_par_err = 0; rx2_idle_err = 0;
        wait_n(2);
    endtask

    function automatic logic [7:0] gen_exp(input logic [7:0] c, input logic sclk, input logic sbit);
        return {c[7:2], sclk, sbit};
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0]  b;
        logic [7:0]  ctl;
        logic [31:0] w;
        int          p0, m0, q1, q2;
        void'($urandom(32'h5EED_0429));
        wait_n(5);
        rst = 1'b0;
        wait_n(4);

        // R13: reset state
        check("R13 dout", bus_dout, 0);
        check("R13 labels", {rx1_label, rx2_label}, 0);
        check("R13 ctrl outs", {clk_sel, tx_fast, rx2_fast, rx1_fast, parity_odd, rx2_reset, rx1_reset}, 0);
        check("R13 master_reset", master_reset, 0);
        bus_rd(3'b000, b); release_cs();
        check("R13 irq after reset", b, 0);

        // R6/R8: random control words
        for (int it = 0; it < 8; it++) begin
            ctl = 8'($urandom());
            tx_ser_bit = 1'($urandom()); tx_ser_clk = 1'($urandom());
            bus_wr(3'b011, ctl); release_cs();
            check("R6 ctrl fields", {clk_sel, tx_fast, rx2_fast, rx1_fast, parity_odd}, ctl[7:2]);
            check("R6 rx resets held", {rx2_reset, rx1_reset}, ctl[1:0]);
            bus_rd(3'b011, b); release_cs();
            check("R8 gen status", b, gen_exp(ctl, tx_ser_clk, tx_ser_bit));
        end
        ctl = 8'hA4;
        bus_wr(3'b011, ctl); release_cs();

        // R7: status flags
        tx_empty = 1'b1;
        rx_pulse(1, 1, 1, 0);
        rx_pulse(2, 0, 0, 1);
        bus_rd(3'b000, b); release_cs();
        check("R7 irq rx1 word+perr, rx2 idle, tx empty", b, 8'b0110_0011);
        rx_pulse(2, 1, 0, 0);
        tx_empty = 1'b0; tx_full = 1'b1;
        bus_rd(3'b000, b); release_cs();
        check("R7 rx2 word clears idle, tx full", b, 8'b1000_1011);
        tx_full = 1'b0;
        rx_pulse(1, 1, 0, 0);
        bus_rd(3'b000, b); release_cs();
        check("R7 rx1 parity flag reloaded", b, 8'b0000_1001);

        // R2/R3: receive data byte order and wrap, random words
        for (int it = 0; it < 6; it++) begin
            rx1_data = $urandom(); rx2_data = $urandom();
            for (int k = 0; k < 6; k++) begin
                bus_rd(3'b001, b);
                check(k < 4 ? "R2 rx1 byte" : "R3 rx1 wrap", b, rx1_data[8*(k%4) +: 8]);
            end
            release_cs();
            for (int k = 0; k < 5; k++) begin
                bus_rd(3'b010, b);
                check(k < 4 ? "R2 rx2 byte" : "R3 rx2 wrap", b, rx2_data[8*(k%4) +: 8]);
            end
            release_cs();
        end

        // R1: upper address half reads zero
        bus_rd(3'b100, b); check("R1 read 100", b, 0);
        bus_rd(3'b111, b); check("R1 read 111", b, 0);
        release_cs();
        check("R1 dout idle", bus_dout, 0);

        // R4: transmit assembly, random words
        for (int it = 0; it < 8; it++) begin
            w = $urandom();
            p0 = push_cnt;
            for (int k = 0; k < 3; k++) bus_wr(3'b000, w[8*k +: 8]);
            check("R4 no push before byte 4", push_cnt, p0);
            bus_wr(3'b000, w[31:24]); release_cs();
            check("R4 one push", push_cnt, p0 + 1);
            check("R4 tx word", last_push, w);
        end

        // R5: full queue drops word
        tx_full = 1'b1;
        p0 = push_cnt;
        wr_word(32'hDEAD_BEEF);
        check("R5 no push when full", push_cnt, p0);
        tx_full = 1'b0;

        // R12: chip select release / address change return to byte 1
        rx1_data = 32'h4433_2211;
        bus_rd(3'b001, b); bus_rd(3'b001, b); release_cs();
        bus_rd(3'b001, b);
        check("R12 cs release restarts read", b, 8'h11);
        bus_rd(3'b001, b);
        bus_rd(3'b000, b);
        bus_rd(3'b001, b);
        check("R12 address change restarts read", b, 8'h11);
        release_cs();
        p0 = push_cnt;
        bus_wr(3'b000, 8'hEE); bus_wr(3'b000, 8'hEE); release_cs();
        wr_word(32'h8765_4321);
        check("R12 tx restart push count", push_cnt, p0 + 1);
        check("R12 tx restart word", last_push, 32'h8765_4321);

        // R11: label writes
        rx_pulse(1, 1, 1, 0);
        rx_pulse(2, 1, 0, 0);
        q1 = r1_pulses; q2 = r2_pulses;
        bus_wr(3'b001, 8'h5A); release_cs();
        check("R11 label value", rx1_label, 8'h5A);
        check("R11 rx1 reset pulse", r1_pulses, q1 + 1);
        check("R11 rx2 untouched", r2_pulses, q2);
        bus_rd(3'b000, b); release_cs();
        check("R11 rx1 flags cleared, rx2 kept", b, 8'b0000_1000);
        bus_wr(3'b001, 8'h5A); release_cs();
        check("R11 same value resets again", r1_pulses, q1 + 2);
        bus_wr(3'b010, 8'hC3); release_cs();
        check("R11 rx2 label", {rx2_label, rx1_label}, {8'hC3, 8'h5A});
        check("R11 rx2 reset pulse", r2_pulses, q2 + 1);

        // R9: master reset by write
        rx_pulse(1, 1, 0, 0);
        rx_pulse(2, 0, 0, 1);
        m0 = mr_cycles; q1 = r1_pulses; q2 = r2_pulses;
        bus_wr(3'b110, 8'($urandom())); release_cs();
        check("R9 single master reset cycle", mr_cycles, m0 + 1);
        check("R9 receivers reset", {r2_pulses, r1_pulses}, {q2 + 1, q1 + 1});
        check("R9 ctrl kept", {clk_sel, tx_fast, rx2_fast, rx1_fast, parity_odd}, ctl[7:2]);
        check("R9 labels kept", {rx1_label, rx2_label}, {8'h5A, 8'hC3});
        bus_rd(3'b000, b); release_cs();
        check("R9 flags cleared", b, 0);

        // R10: hardware reset pin
        rx_pulse(2, 1, 1, 0);
        m0 = mr_cycles;
        hard_reset_n = 1'b0; wait_n(10); hard_reset_n = 1'b1; wait_n(6);
        check("R10 master reset duration", mr_cycles, m0 + 10);
        check("R10 ctrl kept", {clk_sel, tx_fast, rx2_fast, rx1_fast, parity_odd}, ctl[7:2]);
        bus_rd(3'b000, b); release_cs();
        check("R10 flags cleared", b, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule